// File: doc/BRIEF.md
# String Move and Fill Step Sequencer

This block carries out a single step of a repeated string operation: either a move, where one element is read from the source pointer and written to the destination pointer, or a fill, where the low bytes of an accumulator value are written to the destination pointer. After the transfer both pointers step by the element size, upward or downward depending on a direction input. When the repeat prefix is active the counter is also decremented. A caller starts one step with a strobe, and the block performs its memory traffic over a simple request/acknowledge port. It then returns the updated counter and pointers together with a status.

Repetition is not looped inside the block. When the repeat prefix is set and the counter was nonzero, the step ends with a rerun indication, which tells the instruction sequencer to keep the instruction pointer where it is and issue the same step again. Because the counter and both pointers change in one cycle, an interrupt accepted between steps always sees a state from which the operation can resume. A step that would cross a non-canonical 64-bit pointer or that meets a memory error ends with a fault, and none of the registers change.

Top module: `strop_step_engine`

## Requirements
- R1: With `dir_down`=0, a completed step returns both pointers increased by the element size. For a fill only the destination pointer steps, and `src_out` equals `src_in`.
- R2: With `dir_down`=1, a completed step returns the stepped pointers decreased by the element size.
- R3: With `rep_en`=1 and the counter, taken at the selected address width, equal to 0, the step issues no memory request. It ends with `rerun`=0 and `fault`=0 and returns all three registers unchanged. This check comes before the canonical check.
- R4: With `rep_en`=1 and a nonzero counter, exactly one element is transferred. The counter comes back decremented by one within the address width, and `rerun`=1.
- R5: With `rep_en`=0, exactly one element is transferred whatever the counter holds. The counter comes back unchanged and `rerun`=0.
- R6: `addr_sz` codes are 0 = 16-bit, 1 = 32-bit, and 2 or 3 = 64-bit. Pointer and counter arithmetic wraps inside the low 16 or 32 bits, and the bits above are returned unchanged. `mem_addr` carries the pointer masked to that width.
- R7: With 64-bit addressing, a pointer whose bits 63 down to 47 are not all equal ends the step with `fault`=1, no memory request and unchanged registers. A move checks both pointers; a fill checks only the destination.
- R8: A fill issues no read. It writes the accumulator, masked to the element size, to the destination.
- R9: A memory error on the read or the write ends the step with `fault`=1 and `rerun`=0 and leaves the counter and both pointers unchanged.
- R10: A move issues one read at the source address and then one write at the destination address. The write data is the read data with every byte above the element size cleared.
- R11: `elem_sz` codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. `mem_size` carries the same code during each request.
- R12: `busy` rises the cycle after an accepted `start` and stays high until the step ends. `done` is a one-cycle pulse. A `start` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one step (accepted when idle) |
| op_fill | input | 1 | 1 = fill from accumulator, 0 = move |
| elem_sz | input | 2 | Element size code |
| addr_sz | input | 2 | Address width code |
| dir_down | input | 1 | 1 = pointers decrease |
| rep_en | input | 1 | Repeat prefix active |
| cnt_in | input | 64 | Counter register value |
| src_in | input | 64 | Source pointer value |
| dst_in | input | 64 | Destination pointer value |
| acc_in | input | 64 | Accumulator value for fills |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Element size code of the access |
| mem_addr | output | 64 | Access address, masked to address width |
| mem_wdata | output | 64 | Write data, upper bytes cleared |
| mem_ack | input | 1 | Request completed this cycle |
| mem_err | input | 1 | Completed request failed |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle end-of-step pulse |
| rerun | output | 1 | Re-issue the same instruction |
| fault | output | 1 | Step aborted, registers unchanged |
| cnt_out | output | 64 | Updated counter |
| src_out | output | 64 | Updated source pointer |
| dst_out | output | 64 | Updated destination pointer |

## Verification
The assertions assume that `mem_ack` arrives only while `mem_req` is high, and that `mem_err` matters only together with `mem_ack`. They also compare the results against the values captured at the accepted `start`, which assumes those values are not needed again after acceptance. The bench keeps to these assumptions with a memory model that acknowledges every request in the cycle it is raised and raises `mem_err` only for one reserved address. It drives new register values only at a `start` strobe. The one exception is a deliberate second strobe during a running step, which tests that it is ignored.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WRITE  = 3'd2,
    ST_UPDATE = 3'd3,
    ST_DONE   = 3'd4
  } st_e;

  // element size code -> byte count
  function automatic logic [3:0] elem_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // address width code -> bit mask over a 64-bit register
  function automatic logic [63:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 64'h0000_0000_0000_FFFF;
      2'd1:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/strop_step_unit.sv
module strop_step_unit
  import strop_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [3:0]      amount,
  input  logic            down,
  input  logic [1:0]      asz,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] sum;

  always_comb begin
    mask   = XLEN'(width_mask(asz));
    sum    = down ? (base - XLEN'(amount)) : (base + XLEN'(amount));
    result = (base & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/strop_canon_chk.sv
module strop_canon_chk #(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48
) (
  input  logic [XLEN-1:0] ptr,
  output logic            ok
);
  localparam int TOPN = XLEN - VA_BITS + 1;
  logic [TOPN-1:0] top;

  always_comb begin
    top = ptr[XLEN-1:VA_BITS-1];
    ok  = (top == '0) || (top == '1);
  end
endmodule

// File: rtl/strop_lane_mask.sv
module strop_lane_mask #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] din,
  input  logic [1:0]      esz,
  output logic [XLEN-1:0] dout
);
  localparam int NLANE = XLEN / 8;
  logic [3:0] nbytes;

  assign nbytes = 4'd1 << esz;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign dout[g*8 +: 8] = (g < int'(nbytes)) ? din[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/strop_step_engine.sv
module strop_step_engine
  import strop_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            op_fill,
  input  logic [1:0]      elem_sz,
  input  logic [1:0]      addr_sz,
  input  logic            dir_down,
  input  logic            rep_en,
  input  logic [XLEN-1:0] cnt_in,
  input  logic [XLEN-1:0] src_in,
  input  logic [XLEN-1:0] dst_in,
  input  logic [XLEN-1:0] acc_in,
  output logic            mem_req,
  output logic            mem_we,
  output logic [1:0]      mem_size,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            rerun,
  output logic            fault,
  output logic [XLEN-1:0] cnt_out,
  output logic [XLEN-1:0] src_out,
  output logic [XLEN-1:0] dst_out
);

  st_e state;

  // captured step parameters
  logic            fill_q, down_q, rep_q;
  logic [1:0]      esz_q, asz_q;
  logic [XLEN-1:0] cnt_q, src_q, dst_q, wdata_q;
  logic            rerun_q, fault_q;
  logic [XLEN-1:0] cnt_oq, src_oq, dst_oq;

  logic [XLEN-1:0] amask_in, amask_q;
  logic            accept, cnt_zero, src_ok, dst_ok, ptr_bad;
  logic [XLEN-1:0] lm_in, lm_out;
  logic [XLEN-1:0] src_step, dst_step, cnt_step;

  assign accept   = start && (state == ST_IDLE);
  assign amask_in = XLEN'(width_mask(addr_sz));
  assign amask_q  = XLEN'(width_mask(asz_q));
  assign cnt_zero = (cnt_in & amask_in) == '0;
  assign ptr_bad  = addr_sz[1] && (!dst_ok || (!op_fill && !src_ok));
  assign lm_in    = (state == ST_READ) ? mem_rdata : acc_in;

  strop_canon_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon_src (
    .ptr(src_in), .ok(src_ok));
  strop_canon_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon_dst (
    .ptr(dst_in), .ok(dst_ok));

  strop_lane_mask #(.XLEN(XLEN)) u_lane (
    .din(lm_in), .esz((state == ST_READ) ? esz_q : elem_sz), .dout(lm_out));

  strop_step_unit #(.XLEN(XLEN)) u_step_src (
    .base(src_q), .amount(elem_bytes(esz_q)), .down(down_q), .asz(asz_q),
    .result(src_step));
  strop_step_unit #(.XLEN(XLEN)) u_step_dst (
    .base(dst_q), .amount(elem_bytes(esz_q)), .down(down_q), .asz(asz_q),
    .result(dst_step));
  strop_step_unit #(.XLEN(XLEN)) u_step_cnt (
    .base(cnt_q), .amount(4'd1), .down(1'b1), .asz(asz_q),
    .result(cnt_step));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      fill_q  <= 1'b0;
      down_q  <= 1'b0;
      rep_q   <= 1'b0;
      esz_q   <= '0;
      asz_q   <= '0;
      cnt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      wdata_q <= '0;
      rerun_q <= 1'b0;
      fault_q <= 1'b0;
      cnt_oq  <= '0;
      src_oq  <= '0;
      dst_oq  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            fill_q  <= op_fill;
            down_q  <= dir_down;
            rep_q   <= rep_en;
            esz_q   <= elem_sz;
            asz_q   <= addr_sz;
            cnt_q   <= cnt_in;
            src_q   <= src_in;
            dst_q   <= dst_in;
            cnt_oq  <= cnt_in;
            src_oq  <= src_in;
            dst_oq  <= dst_in;
            rerun_q <= 1'b0;
            fault_q <= 1'b0;
            wdata_q <= lm_out;
            if (rep_en && cnt_zero) begin
              state <= ST_DONE;
            end else if (ptr_bad) begin
              fault_q <= 1'b1;
              state   <= ST_DONE;
            end else if (op_fill) begin
              state <= ST_WRITE;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            if (mem_err) begin
              fault_q <= 1'b1;
              state   <= ST_DONE;
            end else begin
              wdata_q <= lm_out;
              state   <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            if (mem_err) begin
              fault_q <= 1'b1;
              state   <= ST_DONE;
            end else begin
              state <= ST_UPDATE;
            end
          end
        end
        ST_UPDATE: begin
          dst_oq  <= dst_step;
          src_oq  <= fill_q ? src_q : src_step;
          cnt_oq  <= rep_q ? cnt_step : cnt_q;
          rerun_q <= rep_q;
          state   <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_size  = esz_q;
  assign mem_addr  = ((state == ST_READ) ? src_q : dst_q) & amask_q;
  assign mem_wdata = wdata_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign rerun     = rerun_q;
  assign fault     = fault_q;
  assign cnt_out   = cnt_oq;
  assign src_out   = src_oq;
  assign dst_out   = dst_oq;

endmodule

// File: rtl/strop_step_checker.sv
module strop_step_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            op_fill,
  input logic            rep_en,
  input logic [XLEN-1:0] cnt_in,
  input logic [XLEN-1:0] src_in,
  input logic [XLEN-1:0] dst_in,
  input logic            mem_req,
  input logic            mem_we,
  input logic            busy,
  input logic            done,
  input logic            rerun,
  input logic            fault,
  input logic [XLEN-1:0] cnt_out,
  input logic [XLEN-1:0] src_out,
  input logic [XLEN-1:0] dst_out
);
  logic            fill_c, rep_c;
  logic [XLEN-1:0] cnt_c, src_c, dst_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_c <= 1'b0;
      rep_c  <= 1'b0;
      cnt_c  <= '0;
      src_c  <= '0;
      dst_c  <= '0;
    end else if (start && !busy) begin
      fill_c <= op_fill;
      rep_c  <= rep_en;
      cnt_c  <= cnt_in;
      src_c  <= src_in;
      dst_c  <= dst_in;
    end
  end

  assert_fill_no_read_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> !fill_c);

  assert_fault_keeps_regs_R9: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (cnt_out == cnt_c && src_out == src_c && dst_out == dst_c && !rerun));

  assert_no_rep_counter_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !rep_c) |-> (cnt_out == cnt_c && !rerun));

  assert_rerun_only_with_rep_R4: assert property (@(posedge clk) disable iff (rst)
    (done && rerun) |-> (rep_c && !fault));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_after_start_R12: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_fill_keeps_src_R1: assert property (@(posedge clk) disable iff (rst)
    (done && fill_c) |-> (src_out == src_c));
endmodule

bind strop_step_engine strop_step_checker #(.XLEN(XLEN)) u_strop_step_checker (
  .clk(clk), .rst(rst), .start(start), .op_fill(op_fill), .rep_en(rep_en),
  .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in),
  .mem_req(mem_req), .mem_we(mem_we), .busy(busy), .done(done),
  .rerun(rerun), .fault(fault),
  .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out));

// File: tb/test_strop_step_engine.sv
module test_strop_step_engine;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam logic [63:0] ERR_ADDR = 64'h0000_0000_0000_DEA0;
  localparam logic [63:0] PAT_KEY  = 64'h0F1E2D3C4B5A6978;
  localparam logic [63:0] ACC_VAL  = 64'h1122_3344_5566_7788;

  typedef struct packed {
    logic        fill;
    logic [1:0]  esz;
    logic [1:0]  asz;
    logic        dir;
    logic        rep;
    logic [63:0] cnt;
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] ecnt;
    logic [63:0] esrc;
    logic [63:0] edst;
    logic        erer;
    logic        eflt;
    logic        erd;
    logic        ewr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    // 0: R1 R5 byte move up, no repeat
    '{1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 64'd5, 64'h1000, 64'h2000,
      64'd5, 64'h1001, 64'h2001, 1'b0, 1'b0, 1'b1, 1'b1},
    // 1: R2 R4 qword move down, repeat
    '{1'b0, 2'd3, 2'd2, 1'b1, 1'b1, 64'd3, 64'h1010, 64'h2010,
      64'd2, 64'h1008, 64'h2008, 1'b1, 1'b0, 1'b1, 1'b1},
    // 2: R6 16-bit wrap of pointers and counter
    '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 64'h1234_0000_0000_0001,
      64'hAAAA_0000_0000_FFFF, 64'h0000_0000_0001_FFFE,
      64'h1234_0000_0000_0000, 64'hAAAA_0000_0000_0001, 64'h0000_0000_0001_0000,
      1'b1, 1'b0, 1'b1, 1'b1},
    // 3: R3 repeat with zero counter at 32-bit width
    '{1'b0, 2'd2, 2'd1, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'h40, 64'h80,
      64'hFFFF_FFFF_0000_0000, 64'h40, 64'h80, 1'b0, 1'b0, 1'b0, 1'b0},
    // 4: R8 R6 dword fill down with 32-bit wrap
    '{1'b1, 2'd2, 2'd1, 1'b1, 1'b1, 64'h10, 64'h5, 64'h0000_0007_0000_0002,
      64'hF, 64'h5, 64'h0000_0007_FFFF_FFFE, 1'b1, 1'b0, 1'b0, 1'b1},
    // 5: R8 R11 byte fill up, no repeat
    '{1'b1, 2'd0, 2'd2, 1'b0, 1'b0, 64'd9, 64'h77, 64'h3000,
      64'd9, 64'h77, 64'h3001, 1'b0, 1'b0, 1'b0, 1'b1},
    // 6: R7 move with non-canonical source
    '{1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 64'd4, 64'h0000_8000_0000_0000, 64'h500,
      64'd4, 64'h0000_8000_0000_0000, 64'h500, 1'b0, 1'b1, 1'b0, 1'b0},
    // 7: R7 fill ignores non-canonical source
    '{1'b1, 2'd3, 2'd2, 1'b0, 1'b0, 64'd7, 64'h0000_8000_0000_0000,
      64'hFFFF_8000_0000_0000, 64'd7, 64'h0000_8000_0000_0000,
      64'hFFFF_8000_0000_0008, 1'b0, 1'b0, 1'b0, 1'b1},
    // 8: R9 write error
    '{1'b0, 2'd0, 2'd2, 1'b0, 1'b1, 64'd4, 64'h100, ERR_ADDR,
      64'd4, 64'h100, ERR_ADDR, 1'b0, 1'b1, 1'b1, 1'b1},
    // 9: R6 R7 R5 16-bit addressing ignores upper bits, zero counter without repeat
    '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 64'd0, 64'h0000_8000_0000_0010, 64'h20,
      64'd0, 64'h0000_8000_0000_0011, 64'h21, 1'b0, 1'b0, 1'b1, 1'b1},
    // 10: R9 R10 read error
    '{1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 64'd1, ERR_ADDR, 64'h200,
      64'd1, ERR_ADDR, 64'h200, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_fill = 1'b0, dir_down = 1'b0, rep_en = 1'b0;
  logic [1:0] elem_sz = '0, addr_sz = '0;
  logic [63:0] cnt_in = '0, src_in = '0, dst_in = '0, acc_in = ACC_VAL;
  logic mem_req, mem_we, mem_ack, mem_err;
  logic [1:0] mem_size;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic busy, done, rerun, fault;
  logic [63:0] cnt_out, src_out, dst_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit timed_out = 1'b0;

  logic mon_clr = 1'b0;
  int rd_n, wr_n;
  logic [63:0] rd_addr, wr_addr, wr_data;
  logic [1:0]  last_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_ack   = mem_req;
  assign mem_err   = mem_req && (mem_addr == ERR_ADDR);
  assign mem_rdata = mem_addr ^ PAT_KEY;

  always @(posedge clk) begin
    if (mon_clr) begin
      rd_n <= 0; wr_n <= 0;
    end else if (mem_req) begin
      last_size <= mem_size;
      if (mem_we) begin
        wr_n <= wr_n + 1; wr_addr <= mem_addr; wr_data <= mem_wdata;
      end else begin
        rd_n <= rd_n + 1; rd_addr <= mem_addr;
      end
    end
  end

  strop_step_engine #(.XLEN(XLEN)) i_strop_step_engine (
    .clk(clk), .rst(rst), .start(start), .op_fill(op_fill),
    .elem_sz(elem_sz), .addr_sz(addr_sz), .dir_down(dir_down), .rep_en(rep_en),
    .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in), .acc_in(acc_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .rerun(rerun), .fault(fault),
    .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out));

  function automatic logic [63:0] amask(input logic [1:0] a);
    return (a == 2'd0) ? 64'hFFFF : (a == 2'd1) ? 64'hFFFF_FFFF : '1;
  endfunction

  function automatic logic [63:0] emask(input logic [1:0] e);
    return (e == 2'd3) ? '1 : ((64'd1 << (8 * (1 << e))) - 64'd1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_step(input vec_t v);
    int wd;
    @(negedge clk);
    op_fill = v.fill; elem_sz = v.esz; addr_sz = v.asz; dir_down = v.dir;
    rep_en = v.rep; cnt_in = v.cnt; src_in = v.src; dst_in = v.dst;
    start = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; mon_clr = 1'b0;
    wd = 0;
    while (!done && wd < 100) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      timed_out = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL R12: watchdog, actual done=0 expected done=1");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R12
    chk("R12 reset busy", 64'(busy), 64'd0);
    chk("R12 reset done", 64'(done), 64'd0);
    chk("R9 reset fault", 64'(fault), 64'd0);
    chk("R11 reset mem_req", 64'(mem_req), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      tg = $sformatf("vec%0d", i);
      run_step(v);
      chk({tg, " R4/R5 cnt"}, cnt_out, v.ecnt);
      chk({tg, " R1/R2 src"}, src_out, v.esrc);
      chk({tg, " R1/R2 dst"}, dst_out, v.edst);
      chk({tg, " R4 rerun"}, 64'(rerun), 64'(v.erer));
      chk({tg, " R7/R9 fault"}, 64'(fault), 64'(v.eflt));
      chk({tg, " R3/R8 reads"}, 64'(rd_n), 64'(v.erd));
      chk({tg, " R3/R10 writes"}, 64'(wr_n), 64'(v.ewr));
      if (v.erd)
        chk({tg, " R10 read addr"}, rd_addr, v.src & amask(v.asz));
      if (v.ewr && !v.eflt) begin
        chk({tg, " R6 write addr"}, wr_addr, v.dst & amask(v.asz));
        chk({tg, " R8/R10 write data"}, wr_data,
            (v.fill ? ACC_VAL : ((v.src & amask(v.asz)) ^ PAT_KEY)) & emask(v.esz));
        chk({tg, " R11 size"}, 64'(last_size), 64'(v.esz));
      end
      // R12: done is a one-cycle pulse
      @(negedge clk);
      chk({tg, " R12 done pulse"}, 64'(done), 64'd0);
    end

    // R12: a second start while busy is ignored
    begin
      vec_t v;
      int wd;
      v = VECS[0];
      @(negedge clk);
      op_fill = v.fill; elem_sz = v.esz; addr_sz = v.asz; dir_down = v.dir;
      rep_en = v.rep; cnt_in = v.cnt; src_in = v.src; dst_in = v.dst;
      start = 1'b1; mon_clr = 1'b1;
      @(negedge clk);
      mon_clr = 1'b0;
      chk("R12 busy after start", 64'(busy), 64'd1);
      src_in = 64'h9000; dst_in = 64'h9100; cnt_in = 64'd50; rep_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wd = 0;
      while (!done && wd < 100) begin @(negedge clk); wd++; end
      chk("R12 busy start ignored src", src_out, v.esrc);
      chk("R12 busy start ignored dst", dst_out, v.edst);
      chk("R12 busy start ignored cnt", cnt_out, v.ecnt);
      chk("R12 busy start ignored writes", 64'(wr_n), 64'd1);
      @(negedge clk);
      @(negedge clk);
      chk("R12 idle after step", 64'(busy), 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL R12: global watchdog expired, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule